// File: doc/BRIEF.md
# USB Device Control and Transceiver Configuration Registers

This block holds the two software-visible registers that sit between a CPU register port and a full/low-speed USB device engine. The control register carries a ping-pong pointer reset, a packet-disable flag, a resume request and a suspend request. The configuration register carries the pull-up enable, the transceiver select, the bus speed and the ping-pong buffering mode. The serial interface engine (SIE) can set the packet-disable flag by itself when a SETUP token arrives. Software can only clear that flag, and clearing it lets transfers continue.

Beyond the register file, the block turns the stored bits into the signals the rest of the device uses. It forces the ping-pong buffer pointers back to the even buffer. It produces a registered SIE clock enable that drops while the device is suspended. It picks which pull-up to assert. It routes the SIE line signals either to the on-chip transceiver or to an off-chip one. The transceiver that is not selected is parked in the idle (J) state. While suspend is set, the selected transceiver is held idle. While resume is set, the K state is driven onto the bus.

Top module: `usb_ctl_regs`

## Requirements
- R1: After reset both registers read 0x00, `pkt_dis` is 0, `pp_ptr_rst` is 0 and `sie_clk_en` is 1.
- R2: Address 0 is the control register, with writable bits 6 (pointer reset), 2 (resume) and 1 (suspend). Address 1 is the configuration register, with writable bits 4 (pull-up enable), 3 (off-chip transceiver select), 2 (full speed) and 1:0 (ping-pong mode). Bit 4 of the control register reads the packet-disable flag. All other bits read 0. Addresses 2 and 3 read 0x00, and writes to them change nothing.
- R3: A cycle with `sie_setup_rx` high sets the packet-disable flag at the next edge. A CPU write to the control register with bit 4 = 0 clears the flag. A write with bit 4 = 1 never sets it. When a setup arrives in the same cycle as a clearing write, the flag ends up set.
- R4: `pp_ptr_rst` is 1 exactly when control bit 6 is 1 and the ping-pong mode field is not 0. Mode 0 means no ping-pong buffering.
- R5: `sie_clk_en` is registered. It equals the inverse of the suspend bit as it stood one clock earlier, so it falls one edge after the suspend bit is written.
- R6: With configuration bit 3 = 0, the SIE outputs drive the on-chip pins and the SIE receive inputs come from the on-chip transceiver. The off-chip side is parked with `xt_oe_n` = 1. With bit 3 = 1 the roles swap and `otx_oe` = 0. The two sides are never enabled to drive at the same time.
- R7: The idle J state is D+ = 1, D- = 0 at full speed (configuration bit 2 = 1) and D+ = 0, D- = 1 at low speed. A parked transceiver shows J with its output enable off.
- R8: `dp_pullup` = 1 only when the pull-up is enabled, the on-chip transceiver is selected and full speed is set. `dm_pullup` = 1 under the same conditions but with low speed. Both are 0 when the off-chip transceiver is selected.
- R9: While suspend is 1 and resume is 0, the selected transceiver shows J with its output enable off, whatever the SIE drives.
- R10: While resume is 1, the selected transceiver drives the K state (the inverse of J) with its output enable on. This overrides both the SIE and suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| sie_setup_rx | input | 1 | SIE saw a SETUP token (one-cycle pulse) |
| pkt_dis | output | 1 | Packet transfers disabled |
| pp_ptr_rst | output | 1 | Force ping-pong pointers to even buffer |
| resume_on | output | 1 | Resume signaling in progress |
| sie_clk_en | output | 1 | Registered SIE clock enable |
| full_speed | output | 1 | Full-speed select |
| dp_pullup | output | 1 | On-chip D+ pull-up enable |
| dm_pullup | output | 1 | On-chip D- pull-up enable |
| sie_dp | input | 1 | SIE transmit D+ |
| sie_dm | input | 1 | SIE transmit D- |
| sie_oe | input | 1 | SIE transmit enable |
| sie_rx_dp | output | 1 | Received D+ to SIE |
| sie_rx_dm | output | 1 | Received D- to SIE |
| sie_rx_rcv | output | 1 | Received differential data to SIE |
| otx_dp | output | 1 | On-chip transceiver D+ drive |
| otx_dm | output | 1 | On-chip transceiver D- drive |
| otx_oe | output | 1 | On-chip transceiver output enable |
| otx_dp_in | input | 1 | On-chip transceiver D+ receive |
| otx_dm_in | input | 1 | On-chip transceiver D- receive |
| otx_rcv_in | input | 1 | On-chip differential receive |
| xt_vpo | output | 1 | Off-chip transceiver D+ drive |
| xt_vmo | output | 1 | Off-chip transceiver D- drive |
| xt_oe_n | output | 1 | Off-chip output enable, active low |
| xt_vp | input | 1 | Off-chip D+ receive |
| xt_vm | input | 1 | Off-chip D- receive |
| xt_rcv | input | 1 | Off-chip differential receive |

## Verification
The checker watches several properties on every cycle:
- a SETUP pulse is always followed by a set packet-disable flag, and the flag never rises without one;
- the clock enable tracks the previous cycle's suspend bit;
- the pointer reset stays low in non-ping-pong mode;
- the two pull-ups are exclusive and both off when the off-chip transceiver is selected;
- the two transceivers never drive together;
- resume and suspend force the selected side's output enable.

Only the bench scenarios can show the rest:
- the exact read-back values and the bits that read 0;
- that writes to unmapped addresses are ignored;
- the J and K polarities at each speed;
- that the receive path follows the selected transceiver.

// File: rtl/usb_ctl_pkg.sv
package usb_ctl_pkg;
  // control register bit positions
  localparam int CTL_PPRST  = 6;
  localparam int CTL_PKTDIS = 4;
  localparam int CTL_RESUME = 2;
  localparam int CTL_SUSP   = 1;
  // configuration register bit positions
  localparam int CFG_PUE    = 4;
  localparam int CFG_XDIS   = 3;
  localparam int CFG_FS     = 2;
  localparam int CFG_PPM_LO = 0;
  localparam int PPM_W      = 2;

  typedef struct packed {
    logic pprst;
    logic pktdis;
    logic resume;
    logic susp;
  } ctl_t;

  typedef struct packed {
    logic             pue;
    logic             xdis;
    logic             fs;
    logic [PPM_W-1:0] ppm;
  } cfg_t;

  typedef struct packed {
    logic dp;
    logic dm;
    logic oe;
  } line_t;

  typedef struct packed {
    logic dp;
    logic dm;
    logic rcv;
  } rx_t;
endpackage

// File: rtl/usb_ctl_ctrlreg.sv
module usb_ctl_ctrlreg
  import usb_ctl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          setup_rx,
  output ctl_t          ctl_q,
  output logic          clk_en_q,
  output logic [DW-1:0] rdata
);
  ctl_t ctl_d;
  logic ctl_ce;
  logic clk_en_d;

  // next-state
  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) begin
      ctl_d.pprst  = wdata[CTL_PPRST];
      ctl_d.resume = wdata[CTL_RESUME];
      ctl_d.susp   = wdata[CTL_SUSP];
      if (!wdata[CTL_PKTDIS]) ctl_d.pktdis = 1'b0;
    end
    if (setup_rx) ctl_d.pktdis = 1'b1;
  end

  assign ctl_ce   = wr_en | setup_rx;
  assign clk_en_d = ~ctl_q.susp;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_ce) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_en_q <= 1'b1;
    end else begin
      clk_en_q <= clk_en_d;
    end
  end

  // read view
  always_comb begin
    rdata             = '0;
    rdata[CTL_PPRST]  = ctl_q.pprst;
    rdata[CTL_PKTDIS] = ctl_q.pktdis;
    rdata[CTL_RESUME] = ctl_q.resume;
    rdata[CTL_SUSP]   = ctl_q.susp;
  end
endmodule

// File: rtl/usb_ctl_cfgreg.sv
module usb_ctl_cfgreg
  import usb_ctl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output cfg_t          cfg_q,
  output logic [DW-1:0] rdata
);
  cfg_t cfg_d;

  always_comb begin
    cfg_d      = cfg_q;
    cfg_d.pue  = wdata[CFG_PUE];
    cfg_d.xdis = wdata[CFG_XDIS];
    cfg_d.fs   = wdata[CFG_FS];
    cfg_d.ppm  = wdata[CFG_PPM_LO +: PPM_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

  always_comb begin
    rdata                         = '0;
    rdata[CFG_PUE]                = cfg_q.pue;
    rdata[CFG_XDIS]               = cfg_q.xdis;
    rdata[CFG_FS]                 = cfg_q.fs;
    rdata[CFG_PPM_LO +: PPM_W]    = cfg_q.ppm;
  end
endmodule

// File: rtl/usb_ctl_linemux.sv
module usb_ctl_linemux
  import usb_ctl_pkg::*;
(
  input  logic  xdis,
  input  logic  fs,
  input  logic  susp,
  input  logic  resume,
  input  line_t sie_tx,
  input  rx_t   otx_rx,
  input  rx_t   xt_rx,
  output line_t otx_tx,
  output line_t xt_tx,
  output rx_t   sie_rx
);
  line_t j_st;
  line_t k_st;
  line_t act;

  always_comb begin
    j_st.dp = fs;
    j_st.dm = ~fs;
    j_st.oe = 1'b0;
    k_st.dp = ~fs;
    k_st.dm = fs;
    k_st.oe = 1'b1;
  end

  // resume beats suspend, suspend beats SIE traffic
  always_comb begin
    if (resume)    act = k_st;
    else if (susp) act = j_st;
    else           act = sie_tx;
  end

  always_comb begin
    if (xdis) begin
      xt_tx  = act;
      otx_tx = j_st;
      sie_rx = xt_rx;
    end else begin
      otx_tx = act;
      xt_tx  = j_st;
      sie_rx = otx_rx;
    end
  end
endmodule

// File: rtl/usb_ctl_regs.sv
module usb_ctl_regs
  import usb_ctl_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          ADDR_W   = 2,
  parameter int unsigned CTL_ADDR = 0,
  parameter int unsigned CFG_ADDR = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          sie_setup_rx,
  output logic          pkt_dis,
  output logic          pp_ptr_rst,
  output logic          resume_on,
  output logic          sie_clk_en,
  output logic          full_speed,
  output logic          dp_pullup,
  output logic          dm_pullup,
  input  logic          sie_dp,
  input  logic          sie_dm,
  input  logic          sie_oe,
  output logic          sie_rx_dp,
  output logic          sie_rx_dm,
  output logic          sie_rx_rcv,
  output logic          otx_dp,
  output logic          otx_dm,
  output logic          otx_oe,
  input  logic          otx_dp_in,
  input  logic          otx_dm_in,
  input  logic          otx_rcv_in,
  output logic          xt_vpo,
  output logic          xt_vmo,
  output logic          xt_oe_n,
  input  logic          xt_vp,
  input  logic          xt_vm,
  input  logic          xt_rcv
);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);

  ctl_t          ctl_q;
  cfg_t          cfg_q;
  logic          ctl_wr, cfg_wr;
  logic [DW-1:0] ctl_rd, cfg_rd;
  line_t         sie_tx, otx_tx, xt_tx;
  rx_t           otx_rx, xt_rx, sie_rx;
  logic          onchip_pu;

  assign ctl_wr = reg_wr && (reg_addr == CTL_A);
  assign cfg_wr = reg_wr && (reg_addr == CFG_A);

  usb_ctl_ctrlreg #(.DW(DW)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctl_wr),
    .wdata    (reg_wdata),
    .setup_rx (sie_setup_rx),
    .ctl_q    (ctl_q),
    .clk_en_q (sie_clk_en),
    .rdata    (ctl_rd)
  );

  usb_ctl_cfgreg #(.DW(DW)) i_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr),
    .wdata (reg_wdata),
    .cfg_q (cfg_q),
    .rdata (cfg_rd)
  );

  always_comb begin
    if (reg_addr == CTL_A)      reg_rdata = ctl_rd;
    else if (reg_addr == CFG_A) reg_rdata = cfg_rd;
    else                        reg_rdata = '0;
  end

  assign pkt_dis    = ctl_q.pktdis;
  assign resume_on  = ctl_q.resume;
  assign pp_ptr_rst = ctl_q.pprst && (cfg_q.ppm != '0);
  assign full_speed = cfg_q.fs;
  assign onchip_pu  = cfg_q.pue && !cfg_q.xdis;
  assign dp_pullup  = onchip_pu && cfg_q.fs;
  assign dm_pullup  = onchip_pu && !cfg_q.fs;

  assign sie_tx = '{dp: sie_dp, dm: sie_dm, oe: sie_oe};
  assign otx_rx = '{dp: otx_dp_in, dm: otx_dm_in, rcv: otx_rcv_in};
  assign xt_rx  = '{dp: xt_vp, dm: xt_vm, rcv: xt_rcv};

  usb_ctl_linemux i_mux (
    .xdis   (cfg_q.xdis),
    .fs     (cfg_q.fs),
    .susp   (ctl_q.susp),
    .resume (ctl_q.resume),
    .sie_tx (sie_tx),
    .otx_rx (otx_rx),
    .xt_rx  (xt_rx),
    .otx_tx (otx_tx),
    .xt_tx  (xt_tx),
    .sie_rx (sie_rx)
  );

  assign otx_dp     = otx_tx.dp;
  assign otx_dm     = otx_tx.dm;
  assign otx_oe     = otx_tx.oe;
  assign xt_vpo     = xt_tx.dp;
  assign xt_vmo     = xt_tx.dm;
  assign xt_oe_n    = ~xt_tx.oe;
  assign sie_rx_dp  = sie_rx.dp;
  assign sie_rx_dm  = sie_rx.dm;
  assign sie_rx_rcv = sie_rx.rcv;
endmodule

// File: rtl/usb_ctl_regs_chk.sv
module usb_ctl_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       setup_rx,
  input logic       pkt_dis,
  input logic       clk_en,
  input logic       susp,
  input logic       resume,
  input logic       xdis,
  input logic [1:0] ppm,
  input logic       pp_ptr_rst,
  input logic       dp_pullup,
  input logic       dm_pullup,
  input logic       otx_oe,
  input logic       xt_oe_n
);
  // R3
  setup_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_rx |=> pkt_dis);
  // R3
  no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_dis && !setup_rx) |=> !pkt_dis);
  // R5
  clk_gate_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (clk_en == !$past(susp)));
  // R4
  pprst_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ppm == 2'b00) |-> !pp_ptr_rst);
  // R8
  pullup_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xdis |-> (!dp_pullup && !dm_pullup && !(dp_pullup && dm_pullup)));
  // R6
  single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(otx_oe && !xt_oe_n));
  // R10
  resume_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> (xdis ? !xt_oe_n : otx_oe));
  // R9
  suspend_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (susp && !resume) |-> (!otx_oe && xt_oe_n));
endmodule

bind usb_ctl_regs usb_ctl_regs_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .setup_rx   (sie_setup_rx),
  .pkt_dis    (pkt_dis),
  .clk_en     (sie_clk_en),
  .susp       (ctl_q.susp),
  .resume     (ctl_q.resume),
  .xdis       (cfg_q.xdis),
  .ppm        (cfg_q.ppm),
  .pp_ptr_rst (pp_ptr_rst),
  .dp_pullup  (dp_pullup),
  .dm_pullup  (dm_pullup),
  .otx_oe     (otx_oe),
  .xt_oe_n    (xt_oe_n)
);

// File: tb/test_usb_ctl_regs.sv
module test_usb_ctl_regs;
  localparam int CLK_P = 10;
  localparam int NVEC  = 10;
  // {addr[2], wdata[8], setup, exp_ctl[8], exp_cfg[8]}
  localparam logic [26:0] VEC [NVEC] = '{
    {2'd0, 8'hFF, 1'b0, 8'h46, 8'h00},  // R2 R3 write 1 cannot set flag
    {2'd1, 8'hFF, 1'b0, 8'h46, 8'h1F},  // R2
    {2'd0, 8'h00, 1'b1, 8'h10, 8'h1F},  // R3 setup wins over clear
    {2'd0, 8'h10, 1'b0, 8'h10, 8'h1F},  // R3 write 1 keeps flag
    {2'd0, 8'h00, 1'b0, 8'h00, 8'h1F},  // R3 clear
    {2'd2, 8'hFF, 1'b0, 8'h00, 8'h1F},  // R2 unmapped ignored
    {2'd3, 8'hFF, 1'b1, 8'h10, 8'h1F},  // R2 R3
    {2'd1, 8'h05, 1'b0, 8'h10, 8'h05},  // R2
    {2'd0, 8'hEF, 1'b0, 8'h46, 8'h05},  // R3 clear via bit4=0
    {2'd0, 8'h00, 1'b0, 8'h00, 8'h05}   // R2
  };

  logic       clk, rst_n;
  logic [1:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sie_setup_rx, pkt_dis, pp_ptr_rst, resume_on, sie_clk_en;
  logic       full_speed, dp_pullup, dm_pullup;
  logic       sie_dp, sie_dm, sie_oe, sie_rx_dp, sie_rx_dm, sie_rx_rcv;
  logic       otx_dp, otx_dm, otx_oe, otx_dp_in, otx_dm_in, otx_rcv_in;
  logic       xt_vpo, xt_vmo, xt_oe_n, xt_vp, xt_vm, xt_rcv;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  usb_ctl_regs i_usb_ctl_regs (.*);

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic s);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; sie_setup_rx = s;
    @(negedge clk);
    reg_wr = 1'b0; sie_setup_rx = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0; sie_setup_rx = 1'b0;
    sie_dp = 1'b0; sie_dm = 1'b0; sie_oe = 1'b0;
    otx_dp_in = 1'b0; otx_dm_in = 1'b0; otx_rcv_in = 1'b0;
    xt_vp = 1'b0; xt_vm = 1'b0; xt_rcv = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, r); chk("R1 ctl", r, 8'h00);
    rd(2'd1, r); chk("R1 cfg", r, 8'h00);
    chk("R1 clk_en", {7'd0, sie_clk_en}, 8'h01);
    chk("R1 pkt_dis", {7'd0, pkt_dis}, 8'h00);
    chk("R1 pp_ptr_rst", {7'd0, pp_ptr_rst}, 8'h00);

    // vector table: R2 R3
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][26:25], VEC[i][24:17], VEC[i][16]);
      rd(2'd0, r); chk($sformatf("R2/R3 vec%0d ctl", i), r, VEC[i][15:8]);
      rd(2'd1, r); chk($sformatf("R2/R3 vec%0d cfg", i), r, VEC[i][7:0]);
    end
    rd(2'd2, r); chk("R2 unmapped read", r, 8'h00);

    // R4 pointer reset qualified by mode
    wr(2'd1, 8'h04, 1'b0);           // mode 0, FS
    wr(2'd0, 8'h40, 1'b0);
    chk("R4 mode0", {7'd0, pp_ptr_rst}, 8'h00);
    wr(2'd1, 8'h06, 1'b0);           // mode 2, FS
    chk("R4 mode2", {7'd0, pp_ptr_rst}, 8'h01);

    // R6 on-chip routing, FS, no suspend
    wr(2'd0, 8'h00, 1'b0);
    wr(2'd1, 8'h04, 1'b0);
    @(negedge clk);
    sie_dp = 1'b1; sie_dm = 1'b0; sie_oe = 1'b1;
    otx_dp_in = 1'b0; otx_dm_in = 1'b1; otx_rcv_in = 1'b1;
    xt_vp = 1'b1; xt_vm = 1'b0; xt_rcv = 1'b0;
    #1;
    chk("R6 otx tx", {5'd0, otx_dp, otx_dm, otx_oe}, 8'h05);
    chk("R6 xt parked", {5'd0, xt_vpo, xt_vmo, xt_oe_n}, 8'h05);
    chk("R6 rx onchip", {5'd0, sie_rx_dp, sie_rx_dm, sie_rx_rcv}, 8'h03);
    // R6 R7 off-chip, LS
    wr(2'd1, 8'h08, 1'b0);
    sie_dp = 1'b0; sie_dm = 1'b0; sie_oe = 1'b1; #1;
    chk("R6 xt tx", {5'd0, xt_vpo, xt_vmo, xt_oe_n}, 8'h00);
    chk("R7 otx LS J", {5'd0, otx_dp, otx_dm, otx_oe}, 8'h02);
    chk("R6 rx offchip", {5'd0, sie_rx_dp, sie_rx_dm, sie_rx_rcv}, 8'h04);

    // R8 pull-ups
    wr(2'd1, 8'h14, 1'b0);
    chk("R8 FS", {6'd0, dp_pullup, dm_pullup}, 8'h02);
    chk("R7 full_speed", {7'd0, full_speed}, 8'h01);
    wr(2'd1, 8'h10, 1'b0);
    chk("R8 LS", {6'd0, dp_pullup, dm_pullup}, 8'h01);
    wr(2'd1, 8'h1C, 1'b0);
    chk("R8 offchip", {6'd0, dp_pullup, dm_pullup}, 8'h00);

    // R5 clock gate timing, R9 suspend idle (on-chip FS)
    wr(2'd1, 8'h14, 1'b0);
    sie_dp = 1'b0; sie_dm = 1'b0; sie_oe = 1'b1;
    @(negedge clk);
    reg_addr = 2'd0; reg_wdata = 8'h02; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R5 clk_en one edge later", {7'd0, sie_clk_en}, 8'h01);
    chk("R9 suspend idle", {5'd0, otx_dp, otx_dm, otx_oe}, 8'h04);
    @(negedge clk);
    chk("R5 clk_en gated", {7'd0, sie_clk_en}, 8'h00);

    // R10 resume overrides suspend: K at FS
    wr(2'd0, 8'h06, 1'b0);
    chk("R10 K drive", {5'd0, otx_dp, otx_dm, otx_oe}, 8'h03);
    chk("R10 resume_on", {7'd0, resume_on}, 8'h01);
    wr(2'd0, 8'h00, 1'b0);
    @(negedge clk);
    chk("R5 clk_en restored", {7'd0, sie_clk_en}, 8'h01);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule